// File: doc/BRIEF.md
# Key-Protected Security Control Register

This block is a 32-bit security control register that sits beside a flash controller. Software changes it only by writing a word whose top byte carries a fixed key. A write with any other key is dropped whole and raises a sticky key-error flag. Software clears that flag through a separate strobe.

The register holds one-way security bits. Their reset state comes from a boot-time lock strap. The configuration write enable, once cleared, stays cleared until the next reset, and it also gates the scramble and silent-access bits. The unlock bit is cleared by writing 1 to it and can never be set again. The execute-never bit is captured from a boot value and is read-only.

A 3-bit row address and a tamper-erase enable complete the register. When the enable is set, a rising edge on the tamper input produces a single-cycle erase request. The request carries the row address that was held at that moment.

Top module: `sec_ctrl_reg`

## Requirements
- R1: A write whose bits 31:24 differ from the key value (0xA5) leaves every readable register bit unchanged.
- R2: A write with a wrong key sets the key-error output on the next clock edge. If a clear strobe arrives in the same cycle, the set wins.
- R3: The key-error output stays at 1 until the clear strobe is seen on a cycle with no wrong-key write. It then reads 0 from the next edge.
- R4: A write with the correct key loads the row address from bits 10:8 and the tamper-erase enable from bit 0. Both read back at the same positions.
- R5: The configuration write enable (bit 4) can be written only while it is 1. Once it is 0, it stays 0 until reset.
- R6: The scramble enable (bit 3) and the silent-access bit (bit 2) take keyed writes only while bit 4 is 1. Otherwise they keep their value and no key error is raised.
- R7: The unlock bit (bit 5) is cleared by a keyed write with bit 5 set. A write of 0 to it has no effect, and once it is 0 it stays 0 until reset.
- R8: During reset, bits 4 and 5 load the inverse of the boot-lock input and bit 6 loads the execute-never boot input. All other state resets to 0.
- R9: The execute-never bit (bit 6) cannot be changed by any write.
- R10: With bit 0 set, a rising edge on the tamper input gives exactly one erase-request cycle on the next edge, with the row address held at the edge. With bit 0 clear, tamper edges produce no request.
- R11: Bits 31:11, 7 and 1 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_lock_i | input | 1 | Boot-time lock strap, sampled during reset |
| xn_boot_i | input | 1 | Boot-time execute-never value, sampled during reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Write data including key byte |
| rd_data_o | output | 32 | Register read value |
| kerr_clr_i | input | 1 | Clears the key-error flag |
| kerr_o | output | 1 | Sticky key-error flag |
| tamper_i | input | 1 | Tamper event input |
| erase_req_o | output | 1 | Single-cycle erase request |
| erase_row_o | output | ROW_W | Row to erase |
| cfg_wen_o | output | 1 | Security configuration write enable |
| unlock_o | output | 1 | Unlock bit |
| xn_o | output | 1 | Execute-never bit |
| scramble_o | output | 1 | Data flash scramble enable |
| silent_o | output | 1 | Silent-access mode |

## Verification
The bench uses the default parameters: a 3-bit row field and the key 0xA5. This covers the full row range and a key byte compared over all eight bits. Two boot-lock strap values are applied across separate resets. This exercises both the open path, where the one-way bits can still be cleared, and the locked path, where keyed writes to gated bits are silently ignored. Tamper edges are tested with the enable on and off, and with the input held high for several cycles to show a single request.

// File: rtl/sec_ctrl_reg.sv
module sec_ctrl_reg #(
  parameter int          ROW_W   = 3,
  parameter logic [7:0]  KEY_VAL = 8'hA5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boot_lock_i,
  input  logic             xn_boot_i,
  input  logic             wr_en_i,
  input  logic [31:0]      wr_data_i,
  output logic [31:0]      rd_data_o,
  input  logic             kerr_clr_i,
  output logic             kerr_o,
  input  logic             tamper_i,
  output logic             erase_req_o,
  output logic [ROW_W-1:0] erase_row_o,
  output logic             cfg_wen_o,
  output logic             unlock_o,
  output logic             xn_o,
  output logic             scramble_o,
  output logic             silent_o
);
  localparam int KEY_LSB = 24;
  localparam int KEY_W   = 8;
  localparam int ROW_LSB = 8;
  localparam int B_TEN   = 0;
  localparam int B_SIL   = 2;
  localparam int B_SCR   = 3;
  localparam int B_CWEN  = 4;
  localparam int B_UNLK  = 5;
  localparam int B_XN    = 6;

  logic [ROW_W-1:0] row_q;
  logic             ten_q;
  logic             tamp_q;

  wire key_hit  = wr_data_i[KEY_LSB +: KEY_W] == KEY_VAL;
  wire wr_ok    = wr_en_i && key_hit;
  wire wr_bad   = wr_en_i && !key_hit;
  wire tamp_edg = tamper_i && !tamp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_wen_o   <= ~boot_lock_i;
      unlock_o    <= ~boot_lock_i;
      xn_o        <= xn_boot_i;
      scramble_o  <= 1'b0;
      silent_o    <= 1'b0;
      ten_q       <= 1'b0;
      row_q       <= '0;
      kerr_o      <= 1'b0;
      tamp_q      <= 1'b0;
      erase_req_o <= 1'b0;
      erase_row_o <= '0;
    end else begin
      if (wr_ok) begin
        row_q <= wr_data_i[ROW_LSB +: ROW_W];
        ten_q <= wr_data_i[B_TEN];
        if (wr_data_i[B_UNLK]) unlock_o <= 1'b0;
        if (cfg_wen_o) begin
          cfg_wen_o  <= wr_data_i[B_CWEN];
          scramble_o <= wr_data_i[B_SCR];
          silent_o   <= wr_data_i[B_SIL];
        end
      end
      if (wr_bad)          kerr_o <= 1'b1;
      else if (kerr_clr_i) kerr_o <= 1'b0;
      tamp_q      <= tamper_i;
      erase_req_o <= tamp_edg && ten_q;
      if (tamp_edg && ten_q) erase_row_o <= row_q;
    end
  end

  always_comb begin
    rd_data_o                    = '0;
    rd_data_o[ROW_LSB +: ROW_W]  = row_q;
    rd_data_o[B_XN]              = xn_o;
    rd_data_o[B_UNLK]            = unlock_o;
    rd_data_o[B_CWEN]            = cfg_wen_o;
    rd_data_o[B_SCR]             = scramble_o;
    rd_data_o[B_SIL]             = silent_o;
    rd_data_o[B_TEN]             = ten_q;
  end

  a_r1_bad_key_discarded: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bad |=> $stable(rd_data_o));
  a_r2_bad_key_flags: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bad |=> kerr_o);
  a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (kerr_o && !kerr_clr_i) |=> kerr_o);
  a_r5_cfg_wen_one_way: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wen_o |=> !cfg_wen_o);
  a_r6_gated_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wen_o |=> $stable({scramble_o, silent_o}));
  a_r7_unlock_one_way: assert property (@(posedge clk) disable iff (!rst_n)
    !unlock_o |=> !unlock_o);
  a_r9_xn_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(xn_o));
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req_o |=> !erase_req_o);
  a_r10_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (!ten_q || !tamper_i) |=> !erase_req_o);
endmodule

// File: tb/sec_ctrl_reg_tb_top.sv
`timescale 1ns/1ps
module sec_ctrl_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_lock = 1'b0, xn_boot = 1'b0;
  logic        wr_en = 1'b0, kerr_clr = 1'b0, tamper = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        kerr, ereq, cwen, unlk, xn, scr, sil;
  logic [2:0]  erow;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  sec_ctrl_reg dut_i (
    .clk(clk), .rst_n(rst_n), .boot_lock_i(boot_lock), .xn_boot_i(xn_boot),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .kerr_clr_i(kerr_clr), .kerr_o(kerr), .tamper_i(tamper),
    .erase_req_o(ereq), .erase_row_o(erow), .cfg_wen_o(cwen),
    .unlock_o(unlk), .xn_o(xn), .scramble_o(scr), .silent_o(sil));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic lock, input logic xb);
    @(negedge clk);
    rst_n = 1'b0; boot_lock = lock; xn_boot = xb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [31:0] d, input logic clr = 1'b0);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; kerr_clr = clr;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; kerr_clr = 1'b0;
  endtask

  task automatic t_reset_open;
    do_reset(1'b0, 1'b1);
    check("R8 open reset read", rd_data, 32'h0000_0070);
    check("R8 open reset flags", {kerr, ereq}, 2'b00);
  endtask

  task automatic t_keyed_write;
    wr(32'hA500_F59F);
    check("R4 R6 R9 R11 keyed write", rd_data, 32'h0000_057D);
    check("R2 no error on good key", kerr, 1'b0);
  endtask

  task automatic t_bad_key;
    wr(32'h3C00_0002);
    check("R1 bad key discarded", rd_data, 32'h0000_057D);
    check("R2 bad key flags", kerr, 1'b1);
    @(negedge clk);
    check("R3 flag sticky", kerr, 1'b1);
    @(negedge clk); kerr_clr = 1'b1;
    @(negedge clk); kerr_clr = 1'b0;
    check("R3 flag cleared", kerr, 1'b0);
    wr(32'h5A00_0000, 1'b1);
    check("R2 set beats clear", kerr, 1'b1);
    @(negedge clk); kerr_clr = 1'b1;
    @(negedge clk); kerr_clr = 1'b0;
    check("R3 flag cleared again", kerr, 1'b0);
  endtask

  task automatic t_unlock;
    wr(32'hA500_051D);
    check("R7 write 0 no effect", unlk, 1'b1);
    wr(32'hA500_053D);
    check("R7 write 1 clears", rd_data, 32'h0000_055D);
    wr(32'hA500_051D);
    check("R7 stays cleared", unlk, 1'b0);
  endtask

  task automatic t_tamper;
    int cnt;
    @(negedge clk); tamper = 1'b1;
    @(negedge clk); tamper = 1'b0;
    check("R10 request with row", {ereq, erow}, {1'b1, 3'd5});
    @(negedge clk);
    check("R10 single cycle", ereq, 1'b0);
    cnt = 0;
    @(negedge clk); tamper = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (i == 2) tamper = 1'b0;
      if (ereq) cnt++;
    end
    check("R10 held input one request", cnt, 1);
    wr(32'hA500_021C);
    check("R4 enable cleared row 2", rd_data, 32'h0000_025C);
    cnt = 0;
    @(negedge clk); tamper = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      tamper = 1'b0;
      if (ereq) cnt++;
    end
    check("R10 disabled no request", cnt, 0);
  endtask

  task automatic t_cfg_lock;
    wr(32'hA500_0204);
    check("R5 R6 lock write", rd_data, 32'h0000_0244);
    wr(32'hA500_021C);
    check("R5 R6 gated bits ignored", rd_data, 32'h0000_0244);
    check("R6 no error on ignored write", kerr, 1'b0);
  endtask

  task automatic t_reset_locked;
    do_reset(1'b1, 1'b0);
    check("R8 locked reset read", rd_data, 32'h0000_0000);
    check("R8 locked reset flags", {kerr, ereq, erow}, 5'b0);
    wr(32'hA500_007C);
    check("R6 R7 R9 locked writes ignored", rd_data, 32'h0000_0000);
    wr(32'hA500_0701);
    check("R4 row 7 enable", rd_data, 32'h0000_0701);
  endtask

  initial begin
    t_reset_open();
    t_keyed_write();
    t_bad_key();
    t_unlock();
    t_tamper();
    t_cfg_lock();
    t_reset_locked();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule